// File: doc/BRIEF.md
# Disc bus target controller

This block is the target side of an 8-bit, active-low, asynchronous disc bus. It waits for an initiator to select it, answers with BSY, and then runs every information transfer phase on its own. Each phase begins by setting the MSG, C/D and I/O lines. After a programmable settling delay the block moves bytes one at a time with a REQ/ACK handshake. When the command is done, it releases the bus.

A 256-byte sector buffer backs the data phases. The first byte of a six-byte command picks whether a data phase runs and in which direction. A read opcode streams the buffer out to the initiator. A write opcode fills the buffer from the initiator. Any other opcode goes straight to status. A local port gives direct read and write access to the buffer, so the buffer can be preloaded and its contents inspected.

All control inputs from the bus pass through a synchronizer before they reach the sequencer. A bus reset also forces every driven line to its deasserted level at once, without waiting for a clock edge.

Top module: `disc_target_ctrl`

## Requirements
- R1: After chip reset, and whenever no command is in progress, the block holds bsy_n, req_n, msg_n, cd_n and io_n high and db_oe low.
- R2: The block asserts bsy_n only when sel_n is low while both bsy_obs_n and io_obs_n are high. If either observed line is low, sel_n gets no answer. The block leaves selection when sel_n returns high.
- R3: During every REQ, {msg_n, cd_n, io_n} is one of five codes: 3'b101 command, 3'b110 data to initiator, 3'b111 data from initiator, 3'b100 status, 3'b000 message.
- R4: {msg_n, cd_n, io_n} settles SETUP_CYC = ceil(450 ns / clock period) cycles before the first REQ of a phase. That is 113 cycles at 4 ns. The lines change only while both REQ and ACK are deasserted.
- R5: req_n is never low unless bsy_n is low.
- R6: The phase order is command (exactly 6 bytes), then an optional data phase, then status, then message. After the message the bus is freed.
- R7: Opcode 8'h08 (first command byte) adds a 256-byte data phase toward the initiator. Opcode 8'h0A adds a 256-byte data phase from the initiator. Every other opcode adds no data phase.
- R8: In the data phase from the initiator, byte k is stored at buffer address k. Bus data is active-low, so the stored byte is ~db_in_n.
- R9: In the data phase toward the initiator, byte k is buffer address k, driven as ~byte on db_out_n with db_oe high. db_oe is high in the status and message phases too.
- R10: The status byte is 8'h00. Exactly one message byte follows, and it is 8'h00. bsy_n goes high after the ACK of that byte is released.
- R11: While bus_rst_n is low, bsy_n, req_n, msg_n, cd_n and io_n are high and db_oe is low in the same cycle. If the reset is held at least 3 cycles, the block returns to bus free, and the next selection starts with a command phase.
- R12: The local port writes lb_wdata at lb_addr when lb_we is high. lb_rdata shows the buffer byte at lb_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| bus_rst_n | input | 1 | Bus reset line, active low |
| sel_n | input | 1 | Select from initiator, active low |
| ack_n | input | 1 | Acknowledge from initiator, active low |
| bsy_obs_n | input | 1 | Observed level of the shared busy line |
| io_obs_n | input | 1 | Observed level of the shared direction line |
| db_in_n | input | 8 | Bus data from initiator, active low |
| bsy_n | output | 1 | Busy, active low |
| req_n | output | 1 | Request, active low |
| msg_n | output | 1 | Message phase line, active low |
| cd_n | output | 1 | Control/data phase line, active low |
| io_n | output | 1 | Direction line, low = toward initiator |
| db_out_n | output | 8 | Bus data toward initiator, active low |
| db_oe | output | 1 | Enable for db_out_n |
| lb_we | input | 1 | Local buffer write enable |
| lb_addr | input | 8 | Local buffer address |
| lb_wdata | input | 8 | Local buffer write data |
| lb_rdata | output | 8 | Local buffer read data |

## Verification
The bench measures the gap between each phase-line change and the next REQ. It expects exactly SETUP_CYC cycles, so an off-by-one timer is caught: firing early breaks the 450 ns rule and firing late fails the exact-gap check. It also flags any line change that happens while ACK is still low. A design that switched phases on the REQ edge, or on ACK assertion, would show up there.

The opcode neighbours 8'h09 and 8'h0B check that the decode does not match on a subset of the opcode bits. The bench writes a pattern through a data-out command and reads it back through a data-in command. A buffer indexed off by one, or with the bus polarity left uninverted, would corrupt that round trip.

A bus reset is raised in the middle of a data-in phase. The driven lines must go high in that same cycle, and the next command must begin with its command phase.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    ST_FREE,
    ST_SELW,
    ST_SETUP,
    ST_REQ,
    ST_ACKW
  } dbt_state_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_DIN,
    PH_DOUT,
    PH_STAT,
    PH_MSG
  } dbt_phase_e;

  // Active-low {msg_n, cd_n, io_n} for a phase.
  function automatic logic [2:0] phase_lines(dbt_phase_e p);
    case (p)
      PH_CMD:  return 3'b101;
      PH_DIN:  return 3'b110;
      PH_DOUT: return 3'b111;
      PH_STAT: return 3'b100;
      PH_MSG:  return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  // Phases in which the target drives the data bus.
  function automatic logic phase_to_init(dbt_phase_e p);
    return (p == PH_DIN) || (p == PH_STAT) || (p == PH_MSG);
  endfunction

endpackage

// File: rtl/dbt_sync.sv
module dbt_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dbt_setup_timer.sv
module dbt_setup_timer #(
  parameter int unsigned CYCLES = 113
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

endmodule

// File: rtl/dbt_sector_buf.sv
module dbt_sector_buf #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Sequencer port written last so it wins an address clash.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];

endmodule

// File: rtl/disc_target_ctrl.sv
module disc_target_ctrl
  import dbt_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned SETUP_NS      = 450,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned CMD_LEN       = 6,
  parameter logic [7:0]  OPC_READ      = 8'h08,
  parameter logic [7:0]  OPC_WRITE     = 8'h0A,
  parameter logic [7:0]  STATUS_GOOD   = 8'h00,
  parameter logic [7:0]  MSG_DONE      = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              sel_n,
  input  logic              ack_n,
  input  logic              bsy_obs_n,
  input  logic              io_obs_n,
  input  logic [7:0]        db_in_n,
  output logic              bsy_n,
  output logic              req_n,
  output logic              msg_n,
  output logic              cd_n,
  output logic              io_n,
  output logic [7:0]        db_out_n,
  output logic              db_oe,
  input  logic              lb_we,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [7:0]        lb_wdata,
  output logic [7:0]        lb_rdata
);

  localparam int unsigned SETUP_CYC = (SETUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned BUF_DEPTH = 1 << ADDR_W;
  localparam int unsigned HW        = $clog2(SETUP_CYC + 1);
  localparam logic [ADDR_W-1:0] CMD_LAST = ADDR_W'(CMD_LEN - 1);
  localparam logic [ADDR_W-1:0] BUF_LAST = ADDR_W'(BUF_DEPTH - 1);

  // ---- input synchronizers ----
  logic [4:0] sync_q;
  dbt_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_rst_n, sel_n, ack_n, bsy_obs_n, io_obs_n}),
    .q     (sync_q)
  );

  logic rst_s, sel_s, ack_s, obs_free, rst_now;
  assign rst_s    = ~sync_q[4];
  assign sel_s    = ~sync_q[3];
  assign ack_s    = ~sync_q[2];
  assign obs_free = sync_q[1] & sync_q[0];
  assign rst_now  = ~bus_rst_n;

  // ---- state ----
  dbt_state_e        state_q, state_d;
  dbt_phase_e        phase_q, phase_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [7:0]        op_q, op_d;
  logic              buf_we;
  logic              tmr_done;
  logic [7:0]        db_byte, buf_rdata, out_byte;
  logic [ADDR_W-1:0] last_idx;
  logic              active;
  logic [2:0]        lines;

  assign db_byte = ~db_in_n;

  function automatic dbt_phase_e after_cmd(logic [7:0] op);
    if (op == OPC_READ)       return PH_DIN;
    else if (op == OPC_WRITE) return PH_DOUT;
    else                      return PH_STAT;
  endfunction

  always_comb begin
    case (phase_q)
      PH_CMD:           last_idx = CMD_LAST;
      PH_DIN, PH_DOUT:  last_idx = BUF_LAST;
      default:          last_idx = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    op_d    = op_q;
    buf_we  = 1'b0;
    case (state_q)
      ST_FREE: if (sel_s && obs_free) state_d = ST_SELW;
      ST_SELW: if (!sel_s) begin
        state_d = ST_SETUP;
        phase_d = PH_CMD;
        idx_d   = '0;
      end
      ST_SETUP: if (tmr_done) state_d = ST_REQ;
      ST_REQ: if (ack_s) begin
        state_d = ST_ACKW;
        if (phase_q == PH_CMD && idx_q == '0) op_d = db_byte;
        if (phase_q == PH_DOUT) buf_we = 1'b1;
      end
      ST_ACKW: if (!ack_s) begin
        if (idx_q == last_idx) begin
          idx_d   = '0;
          state_d = ST_SETUP;
          case (phase_q)
            PH_CMD:           phase_d = after_cmd(op_q);
            PH_DIN, PH_DOUT:  phase_d = PH_STAT;
            PH_STAT:          phase_d = PH_MSG;
            default:          state_d = ST_FREE;
          endcase
        end else begin
          idx_d   = idx_q + ADDR_W'(1);
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_FREE;
    endcase
    if (rst_s) begin
      state_d = ST_FREE;
      idx_d   = '0;
      buf_we  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      phase_q <= PH_CMD;
      idx_q   <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      op_q    <= op_d;
    end
  end

  dbt_setup_timer #(.CYCLES(SETUP_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_SETUP),
    .done  (tmr_done)
  );

  dbt_sector_buf #(.AW(ADDR_W), .DW(8)) u_buf (
    .clk     (clk),
    .a_we    (buf_we),
    .a_addr  (idx_q),
    .a_wdata (db_byte),
    .a_rdata (buf_rdata),
    .b_we    (lb_we),
    .b_addr  (lb_addr),
    .b_wdata (lb_wdata),
    .b_rdata (lb_rdata)
  );

  // ---- bus drivers, forced idle by a raw bus reset ----
  assign active = (state_q == ST_SETUP) || (state_q == ST_REQ) || (state_q == ST_ACKW);

  always_comb begin
    case (phase_q)
      PH_DIN:  out_byte = buf_rdata;
      PH_STAT: out_byte = STATUS_GOOD;
      PH_MSG:  out_byte = MSG_DONE;
      default: out_byte = 8'h00;
    endcase
  end

  assign lines    = (active && !rst_now) ? phase_lines(phase_q) : 3'b111;
  assign msg_n    = lines[2];
  assign cd_n     = lines[1];
  assign io_n     = lines[0];
  assign bsy_n    = ~((state_q != ST_FREE) && !rst_now);
  assign req_n    = ~((state_q == ST_REQ) && !rst_now);
  assign db_oe    = active && phase_to_init(phase_q) && !rst_now;
  assign db_out_n = db_oe ? ~out_byte : 8'hFF;

  // ---- checking logic: cycles the phase lines have been stable ----
  logic [2:0]    lines_q;
  logic [HW-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= 3'b111;
      hold_q  <= '0;
    end else begin
      lines_q <= lines;
      if (lines != lines_q)               hold_q <= '0;
      else if (hold_q != HW'(SETUP_CYC))  hold_q <= hold_q + HW'(1);
    end
  end

  AST_REQ_NEEDS_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> !bsy_n); // R5
  AST_LEGAL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> ({msg_n, cd_n, io_n} inside {3'b101, 3'b110, 3'b111, 3'b100, 3'b000})); // R3
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && $past(req_n)) |-> (hold_q >= HW'(SETUP_CYC - 1))); // R4
  AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsy_n && !$past(bsy_n) && (lines != $past(lines))) |-> ($past(req_n) && !$past(ack_s))); // R4
  AST_SEL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FREE && sel_s && obs_free && !rst_s && !rst_now) |=> (!bsy_n || !bus_rst_n)); // R2
  AST_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FREE && !obs_free) |=> bsy_n); // R2
  AST_RST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> (state_q == ST_FREE)); // R11
  AST_STATUS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q) && phase_q == PH_STAT) |-> ($past(phase_q) inside {PH_CMD, PH_DIN, PH_DOUT})); // R6
  AST_DATA_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q) && (phase_q == PH_DIN || phase_q == PH_DOUT)) |-> ($past(phase_q) == PH_CMD)); // R7

endmodule

// File: tb/disc_target_ctrl_bench.sv
module disc_target_ctrl_bench;

  localparam int PER_PS    = 4000;
  localparam int SETUP_CYC = (450 * 1000 + PER_PS - 1) / PER_PS;
  localparam int WDOG      = 150000;

  logic clk, rst_n, bus_rst_n, sel_n, ack_n, bsy_obs_n, io_obs_n;
  logic [7:0] db_in_n, db_out_n, lb_wdata, lb_rdata, lb_addr;
  logic bsy_n, req_n, msg_n, cd_n, io_n, db_oe, lb_we;

  disc_target_ctrl #(.CLK_PERIOD_PS(PER_PS)) u_disc_target_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .sel_n(sel_n), .ack_n(ack_n),
    .bsy_obs_n(bsy_obs_n), .io_obs_n(io_obs_n), .db_in_n(db_in_n),
    .bsy_n(bsy_n), .req_n(req_n), .msg_n(msg_n), .cd_n(cd_n), .io_n(io_n),
    .db_out_n(db_out_n), .db_oe(db_oe),
    .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=%0d expected<=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // bus monitor: setup gap (R4), lines held (R4), REQ only with BSY (R5)
  logic [2:0] mon_prev_lines = 3'b111;
  logic mon_prev_bsy = 1'b1, mon_prev_req = 1'b1, mon_prev_ack = 1'b1;
  int mon_sc = 0, min_gap = 1000000, n_setup_bad = 0, n_held_bad = 0, n_r5_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ({msg_n, cd_n, io_n} != mon_prev_lines) begin
        mon_sc = 0;
        if (!bsy_n && !mon_prev_bsy && (!mon_prev_req || !mon_prev_ack)) n_held_bad++;
      end else if (mon_sc < 1000000) mon_sc++;
      if (!req_n && mon_prev_req) begin
        if (mon_sc < min_gap) min_gap = mon_sc;
        if (mon_sc < SETUP_CYC) n_setup_bad++;
      end
      if (!req_n && bsy_n) n_r5_bad++;
    end
    mon_prev_lines = {msg_n, cd_n, io_n};
    mon_prev_bsy   = bsy_n;
    mon_prev_req   = req_n;
    mon_prev_ack   = ack_n;
  end

  logic [7:0] model [256];

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return 8'((i * s) + 8'h3C) ^ 8'(i >> 3);
  endfunction

  // results of the last transaction
  logic [14:0] r_order;
  int r_nph, r_ncmd, r_ndata, r_nstat, r_nmsg, r_badcode, r_oebad, r_rxbad;
  logic [7:0] r_stat, r_msg;

  task automatic run_txn(input logic [7:0] op, input logic [7:0] seed, input int abort_at);
    int hs;
    int k;
    logic [2:0] code, last;
    logic [7:0] b;
    r_order = '0; r_nph = 0; r_ncmd = 0; r_ndata = 0; r_nstat = 0; r_nmsg = 0;
    r_badcode = 0; r_oebad = 0; r_rxbad = 0; r_stat = 8'hEE; r_msg = 8'hEE;
    hs = 0; k = 0; last = 3'b011;
    @(negedge clk) sel_n = 1'b0;
    while (bsy_n) @(negedge clk);
    sel_n = 1'b1;
    while (1) begin
      @(negedge clk);
      if (bsy_n) break;
      if (!req_n) begin
        code = {msg_n, cd_n, io_n};
        if (code != last) begin
          r_order = {r_order[11:0], code};
          r_nph++;
          last = code;
          k = 0;
        end
        b = 8'h00;
        case (code)
          3'b101: begin b = (k == 0) ? op : 8'(k); r_ncmd++; end
          3'b111: begin b = pat(seed, k); model[k] = b; r_ndata++; end
          3'b110: begin if (~db_out_n != model[k]) r_rxbad++; r_ndata++; end
          3'b100: begin r_stat = ~db_out_n; r_nstat++; end
          3'b000: begin r_msg = ~db_out_n; r_nmsg++; end
          default: r_badcode++;
        endcase
        if (!io_n && !db_oe) r_oebad++;
        if (io_n) db_in_n = ~b;
        ack_n = 1'b0;
        while (!req_n) @(negedge clk);
        ack_n = 1'b1;
        k++;
        hs++;
        if (abort_at != 0 && hs == abort_at) return;
      end
    end
  endtask

  // opcode, pattern seed, direction (0 none, 1 to initiator, 2 from initiator)
  localparam logic [17:0] VEC [7] = '{
    {8'h08, 8'd11,  2'd1},
    {8'h0A, 8'd5,   2'd2},
    {8'h08, 8'd0,   2'd1},
    {8'h00, 8'd0,   2'd0},
    {8'h0B, 8'd0,   2'd0},
    {8'h09, 8'd0,   2'd0},
    {8'h0A, 8'd200, 2'd2}
  };

  initial begin
    rst_n = 1'b0; bus_rst_n = 1'b1; sel_n = 1'b1; ack_n = 1'b1;
    bsy_obs_n = 1'b1; io_obs_n = 1'b1; db_in_n = 8'hFF;
    lb_we = 1'b0; lb_addr = '0; lb_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk({bsy_n, req_n, msg_n, cd_n, io_n, db_oe} == 6'b111110, "R1 idle after reset",
        {bsy_n, req_n, msg_n, cd_n, io_n, db_oe}, 6'b111110);

    // R12 local port
    @(negedge clk); lb_we = 1'b1; lb_addr = 8'h7F; lb_wdata = 8'hA5;
    @(negedge clk); lb_addr = 8'h00; lb_wdata = 8'h5A;
    @(negedge clk); lb_we = 1'b0; lb_addr = 8'h7F;
    #1 chk(lb_rdata == 8'hA5, "R12 local readback 7F", lb_rdata, 8'hA5);
    @(negedge clk); lb_addr = 8'h00;
    #1 chk(lb_rdata == 8'h5A, "R12 local readback 00", lb_rdata, 8'h5A);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[8'h7F] = 8'hA5; model[8'h00] = 8'h5A;

    // R2 no answer while observed BSY or I/O asserted
    @(negedge clk); bsy_obs_n = 1'b0; sel_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(bsy_n == 1'b1, "R2 no answer with busy seen", bsy_n, 1);
    bsy_obs_n = 1'b1; io_obs_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(bsy_n == 1'b1, "R2 no answer with io seen", bsy_n, 1);
    sel_n = 1'b1; io_obs_n = 1'b1;
    repeat (6) @(negedge clk);

    // table of commands
    for (int v = 0; v < 7; v++) begin
      logic [7:0] op, seed;
      logic [1:0] dir;
      logic [14:0] exp_order;
      int exp_nph, exp_nd, rb_bad;
      {op, seed, dir} = VEC[v];
      if (dir == 2'd1 && seed != 0) begin
        for (int i = 0; i < 256; i++) begin
          @(negedge clk); lb_we = 1'b1; lb_addr = 8'(i); lb_wdata = pat(seed, i) ^ 8'h96;
          model[i] = pat(seed, i) ^ 8'h96;
        end
        @(negedge clk); lb_we = 1'b0;
      end
      run_txn(op, seed, 0);
      case (dir)
        2'd1:    begin exp_order = {3'b101, 3'b110, 3'b100, 3'b000}; exp_nph = 4; exp_nd = 256; end
        2'd2:    begin exp_order = {3'b101, 3'b111, 3'b100, 3'b000}; exp_nph = 4; exp_nd = 256; end
        default: begin exp_order = {3'b101, 3'b100, 3'b000};         exp_nph = 3; exp_nd = 0;   end
      endcase
      chk(r_order == exp_order && r_nph == exp_nph, "R6 R7 phase order", r_order, exp_order);
      chk(r_ncmd == 6, "R6 command byte count", r_ncmd, 6);
      chk(r_ndata == exp_nd, "R7 data byte count", r_ndata, exp_nd);
      chk(r_badcode == 0, "R3 phase codes", r_badcode, 0);
      chk(r_nstat == 1 && r_stat == 8'h00, "R10 status byte", r_stat, 0);
      chk(r_nmsg == 1 && r_msg == 8'h00, "R10 message byte", {r_nmsg[7:0], r_msg}, 16'h0100);
      chk(r_oebad == 0, "R9 data enable", r_oebad, 0);
      chk(bsy_n == 1'b1, "R10 bus released", bsy_n, 1);
      if (dir == 2'd1) chk(r_rxbad == 0, "R9 data to initiator", r_rxbad, 0);
      if (dir == 2'd2) begin
        rb_bad = 0;
        for (int i = 0; i < 256; i++) begin
          @(negedge clk); lb_addr = 8'(i);
          #1 if (lb_rdata != model[i]) rb_bad++;
        end
        chk(rb_bad == 0, "R8 buffer after data out", rb_bad, 0);
      end
      repeat (4) @(negedge clk);
      chk({bsy_n, req_n, msg_n, cd_n, io_n, db_oe} == 6'b111110, "R1 idle between commands",
          {bsy_n, req_n, msg_n, cd_n, io_n, db_oe}, 6'b111110);
    end

    // R11 bus reset in the middle of a data-in phase
    run_txn(8'h08, 8'd0, 16);
    repeat (2) @(negedge clk);
    chk(!bsy_n, "R11 still busy before reset", bsy_n, 0);
    @(negedge clk); bus_rst_n = 1'b0;
    #1 chk({bsy_n, req_n, msg_n, cd_n, io_n, db_oe} == 6'b111110, "R11 lines released at once",
           {bsy_n, req_n, msg_n, cd_n, io_n, db_oe}, 6'b111110);
    repeat (5) @(negedge clk);
    bus_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({bsy_n, req_n, db_oe} == 3'b110, "R11 free after reset", {bsy_n, req_n, db_oe}, 3'b110);
    run_txn(8'h00, 8'd0, 0);
    chk(r_order == {3'b101, 3'b100, 3'b000} && r_nph == 3, "R11 fresh command phase",
        r_order, {3'b101, 3'b100, 3'b000});

    // monitor results
    chk(n_setup_bad == 0 && min_gap == SETUP_CYC, "R4 setup before first REQ", min_gap, SETUP_CYC);
    chk(n_held_bad == 0, "R4 lines held through ACK", n_held_bad, 0);
    chk(n_r5_bad == 0, "R5 REQ only with BSY", n_r5_bad, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule